// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner with Key Matrix

The block drives a dynamically multiplexed fluorescent display. It walks through between 1 and 16 digit strobes, one at a time. For the current digit it fetches a 32-bit segment word from an external display memory and puts it on 24 segment lines. Digit outputs 8 to 15 can each be turned into an extra segment line, which gives up to 32 segment lines in total. Each digit occupies a slot made of prescaled ticks. A slot opens with a two-tick blank in which every output is off, which stops ghosting between digits. A dimmer then keeps the digit lit for a programmable fraction of the slot body, in eighths.

When key scanning is enabled, one extra slot follows the last digit in every frame. In that slot no digit strobe is on, and exactly one segment line is driven, so that line acts as a column of a 16 x 8 key matrix. The column advances by one each frame. At the end of the slot the eight key-return inputs are stored into that column's byte of a 128-bit key-state vector. When a full pass over all 16 columns has produced a different picture from the one before, a sticky change flag is set and a one-cycle interrupt pulse is issued.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: At most one digit strobe is on at any time. Within a frame the digits are lit in ascending order from 0 to `cfg_digits`, so the field value 0..15 selects 1..16 digits.
- R2: While digit d is lit, `ram_addr` equals d and `seg_out` equals bits 23:0 of the display word at address d.
- R3: One tick lasts `TICK_DIV` clock cycles. Each slot is 2 ticks of blank with every output at 0, followed by a body of `cfg_slot_len` ticks. A value of 0 counts as 1.
- R4: In a digit slot the digit is lit for the first max(1, floor((`cfg_dim`+1) x body/8)) ticks of the body and is dark for the rest of the slot.
- R5: When `cfg_seg_mode[k]` is 1, `dig_out[8+k]` never carries a strobe. During every lit window it shows bit 31-k of the current digit's word, and it is 0 at all other times.
- R6: While reset is asserted and right after it, `dig_out`, `seg_out`, `key_state`, `key_chg` and `key_irq` are all 0.
- R7: With `cfg_key_en`=1, exactly one key slot follows the last digit of each frame. For the whole body of that slot `dig_out` is 0 and `seg_out` is one-hot on column c. The column steps by one each frame and wraps from 15 to 0.
- R8: At the last body tick of a key slot, `key_ret` is stored into `key_state[c*8 +: 8]`.
- R9: When the pass ends at column 15 and any column's captured byte differed from its stored byte during that pass, `key_chg` becomes 1 and `key_irq` pulses for exactly one cycle. A pass with no differences raises neither.
- R10: `key_chg` stays set until `key_chg_clr` is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R11: With `cfg_key_en`=0, no key slot occurs and `key_state` keeps its value whatever `key_ret` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_digits | input | 4 | Index of the last scanned digit |
| cfg_slot_len | input | 8 | Slot body length in ticks |
| cfg_dim | input | 3 | Dimmer level, lit eighths minus one |
| cfg_key_en | input | 1 | Enables the key-scan slot |
| cfg_seg_mode | input | 8 | Bit k turns digit output 8+k into segment line 31-k |
| ram_addr | output | 4 | Display memory read address (current digit) |
| ram_data | input | 32 | Display memory read data, asynchronous |
| dig_out | output | 16 | Digit strobes / extra segment lines |
| seg_out | output | 24 | Segment lines, also used as key columns |
| key_ret | input | 8 | Key-return rows |
| key_state | output | 128 | Captured key matrix, 8 bits per column |
| key_chg | output | 1 | Sticky key-change flag |
| key_chg_clr | input | 1 | Clears the key-change flag |
| key_irq | output | 1 | One-cycle key-change interrupt |

## Verification
A software clear of the change flag can land on the same edge as the end of a scan pass that detected a change. The bench provokes this by holding `key_chg_clr` high while it alters one key, so the clear is present on the very edge where the flag is set. In the cycle where `key_irq` is seen it requires `key_chg` to be 1, because the set wins. One cycle later, with the clear still high, it requires the flag to be 0. Display slots are also checked cycle by cycle across frames that contain the key slot, so that column drive and digit drive are shown never to overlap.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    typedef enum logic {
        PH_BLANK = 1'b0,
        PH_BODY  = 1'b1
    } vfd_phase_e;

    localparam int unsigned BLANK_TICKS = 2;
    localparam int unsigned DIM_FRAC_W  = 3;
endpackage

// File: rtl/vfd_tick_gen.sv
module vfd_tick_gen #(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == CW'(TICK_DIV - 1));
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
    import vfd_pkg::*;
#(
    parameter int unsigned DIG_N = 16,
    parameter int unsigned PAT_W = 32,
    parameter int unsigned LEN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [$clog2(DIG_N)-1:0] cfg_digits,
    input  logic [LEN_W-1:0]      cfg_slot_len,
    input  logic [DIM_FRAC_W-1:0] cfg_dim,
    input  logic                  cfg_key_en,
    input  logic [PAT_W-1:0]      ram_data,
    output logic [$clog2(DIG_N)-1:0] digit,
    output logic [PAT_W-1:0]      pattern,
    output logic                  lit,
    output logic                  key_drive,
    output logic                  key_sample
);
    localparam int unsigned DIG_W = $clog2(DIG_N);
    localparam int unsigned PW    = LEN_W + DIM_FRAC_W + 1;

    typedef struct packed {
        vfd_phase_e       phase;
        logic [LEN_W-1:0] cnt;
        logic [DIG_W-1:0] digit;
        logic             in_key;
        logic [PAT_W-1:0] pattern;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [LEN_W-1:0] len_eff;
    logic [PW-1:0]    lit_len;
    logic             body_end;

    always_comb begin
        len_eff = (cfg_slot_len == '0) ? LEN_W'(1) : cfg_slot_len;
        lit_len = ((PW'(cfg_dim) + PW'(1)) * PW'(len_eff)) >> DIM_FRAC_W;
        if (lit_len == '0) lit_len = PW'(1);

        body_end   = (st_q.phase == PH_BODY) && (st_q.cnt >= len_eff - LEN_W'(1));
        lit        = (st_q.phase == PH_BODY) && !st_q.in_key && (PW'(st_q.cnt) < lit_len);
        key_drive  = (st_q.phase == PH_BODY) && st_q.in_key;
        key_sample = tick && body_end && st_q.in_key;

        st_d = st_q;
        if (tick) begin
            if (st_q.phase == PH_BLANK) begin
                if (st_q.cnt == LEN_W'(BLANK_TICKS - 1)) begin
                    st_d.phase   = PH_BODY;
                    st_d.cnt     = '0;
                    st_d.pattern = st_q.in_key ? '0 : ram_data;
                end else begin
                    st_d.cnt = st_q.cnt + LEN_W'(1);
                end
            end else if (body_end) begin
                st_d.phase = PH_BLANK;
                st_d.cnt   = '0;
                if (st_q.in_key) begin
                    st_d.in_key = 1'b0;
                    st_d.digit  = '0;
                end else if (st_q.digit >= cfg_digits) begin
                    st_d.digit  = '0;
                    st_d.in_key = cfg_key_en;
                end else begin
                    st_d.digit = st_q.digit + DIG_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
        end

        digit   = st_q.digit;
        pattern = st_q.pattern;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_BLANK, default: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vfd_key_buf.sv
module vfd_key_buf #(
    parameter int unsigned KEY_ROWS = 8,
    parameter int unsigned KEY_COLS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample,
    input  logic [KEY_ROWS-1:0]          key_ret,
    input  logic                         clr,
    output logic [$clog2(KEY_COLS)-1:0]  col,
    output logic [KEY_ROWS*KEY_COLS-1:0] key_state,
    output logic                         key_chg,
    output logic                         key_irq
);
    localparam int unsigned COL_W = $clog2(KEY_COLS);
    localparam int unsigned KS_W  = KEY_ROWS * KEY_COLS;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [KS_W-1:0]  keys;
        logic             diff;
        logic             flag;
        logic             irq;
    } key_st_t;

    key_st_t st_d, st_q;
    logic    differs;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        differs  = (st_q.keys[st_q.col*KEY_ROWS +: KEY_ROWS] != key_ret);
        if (clr) st_d.flag = 1'b0;
        if (sample) begin
            st_d.keys[st_q.col*KEY_ROWS +: KEY_ROWS] = key_ret;
            if (st_q.col == COL_W'(KEY_COLS - 1)) begin
                st_d.col  = '0;
                st_d.diff = 1'b0;
                if (st_q.diff || differs) begin
                    st_d.flag = 1'b1;
                    st_d.irq  = 1'b1;
                end
            end else begin
                st_d.col  = st_q.col + COL_W'(1);
                st_d.diff = st_q.diff | differs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col       = st_q.col;
    assign key_state = st_q.keys;
    assign key_chg   = st_q.flag;
    assign key_irq   = st_q.irq;
endmodule

// File: rtl/vfd_out_mux.sv
module vfd_out_mux #(
    parameter int unsigned DIG_N    = 16,
    parameter int unsigned SEG_N    = 24,
    parameter int unsigned EXT_N    = 8,
    parameter int unsigned KEY_COLS = 16
) (
    input  logic                         lit,
    input  logic                         key_drive,
    input  logic [$clog2(DIG_N)-1:0]     digit,
    input  logic [SEG_N+EXT_N-1:0]       pattern,
    input  logic [$clog2(KEY_COLS)-1:0]  col,
    input  logic [EXT_N-1:0]             cfg_seg_mode,
    output logic [DIG_N-1:0]             dig_out,
    output logic [SEG_N-1:0]             seg_out
);
    localparam int unsigned PAT_W    = SEG_N + EXT_N;
    localparam int unsigned EXT_BASE = DIG_N - EXT_N;

    logic [DIG_N-1:0] strobe;

    always_comb begin
        strobe = lit ? (DIG_N'(1) << digit) : '0;
        if (lit)            seg_out = pattern[SEG_N-1:0];
        else if (key_drive) seg_out = SEG_N'(1) << col;
        else                seg_out = '0;
    end

    for (genvar i = 0; i < DIG_N; i++) begin : g_dig
        if (i >= EXT_BASE) begin : g_ext
            assign dig_out[i] = cfg_seg_mode[i-EXT_BASE]
                              ? (lit & pattern[PAT_W-1-(i-EXT_BASE)])
                              : strobe[i];
        end else begin : g_plain
            assign dig_out[i] = strobe[i];
        end
    end
endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
    import vfd_pkg::*;
#(
    parameter int unsigned DIG_N    = 16,
    parameter int unsigned SEG_N    = 24,
    parameter int unsigned EXT_N    = 8,
    parameter int unsigned KEY_ROWS = 8,
    parameter int unsigned KEY_COLS = 16,
    parameter int unsigned LEN_W    = 8,
    parameter int unsigned TICK_DIV = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(DIG_N)-1:0]     cfg_digits,
    input  logic [LEN_W-1:0]             cfg_slot_len,
    input  logic [DIM_FRAC_W-1:0]        cfg_dim,
    input  logic                         cfg_key_en,
    input  logic [EXT_N-1:0]             cfg_seg_mode,
    output logic [$clog2(DIG_N)-1:0]     ram_addr,
    input  logic [SEG_N+EXT_N-1:0]       ram_data,
    output logic [DIG_N-1:0]             dig_out,
    output logic [SEG_N-1:0]             seg_out,
    input  logic [KEY_ROWS-1:0]          key_ret,
    output logic [KEY_ROWS*KEY_COLS-1:0] key_state,
    output logic                         key_chg,
    input  logic                         key_chg_clr,
    output logic                         key_irq
);
    localparam int unsigned DIG_W = $clog2(DIG_N);
    localparam int unsigned COL_W = $clog2(KEY_COLS);
    localparam int unsigned PAT_W = SEG_N + EXT_N;

    logic             tick;
    logic [DIG_W-1:0] digit;
    logic [PAT_W-1:0] pattern;
    logic             lit;
    logic             key_drive;
    logic             key_sample;
    logic [COL_W-1:0] col;

    vfd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vfd_slot_seq #(.DIG_N(DIG_N), .PAT_W(PAT_W), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cfg_digits   (cfg_digits),
        .cfg_slot_len (cfg_slot_len),
        .cfg_dim      (cfg_dim),
        .cfg_key_en   (cfg_key_en),
        .ram_data     (ram_data),
        .digit        (digit),
        .pattern      (pattern),
        .lit          (lit),
        .key_drive    (key_drive),
        .key_sample   (key_sample)
    );

    vfd_key_buf #(.KEY_ROWS(KEY_ROWS), .KEY_COLS(KEY_COLS)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (key_sample),
        .key_ret   (key_ret),
        .clr       (key_chg_clr),
        .col       (col),
        .key_state (key_state),
        .key_chg   (key_chg),
        .key_irq   (key_irq)
    );

    vfd_out_mux #(.DIG_N(DIG_N), .SEG_N(SEG_N), .EXT_N(EXT_N), .KEY_COLS(KEY_COLS)) u_mux (
        .lit          (lit),
        .key_drive    (key_drive),
        .digit        (digit),
        .pattern      (pattern),
        .col          (col),
        .cfg_seg_mode (cfg_seg_mode),
        .dig_out      (dig_out),
        .seg_out      (seg_out)
    );

    assign ram_addr = digit;
endmodule

// File: rtl/vfd_scan_sva.sv
module vfd_scan_sva #(
    parameter int unsigned DIG_N = 16,
    parameter int unsigned SEG_N = 24,
    parameter int unsigned EXT_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EXT_N-1:0] cfg_seg_mode,
    input logic [DIG_N-1:0] dig_out,
    input logic [SEG_N-1:0] seg_out,
    input logic             key_chg,
    input logic             key_chg_clr,
    input logic             key_irq
);
    logic [DIG_N-1:0] ext_mask;
    assign ext_mask = {cfg_seg_mode, {(DIG_N-EXT_N){1'b0}}};

    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_out & ~ext_mask));

    p_reset_dark_r6: assert property (@(posedge clk)
        !rst_n |-> (dig_out == '0 && seg_out == '0 && !key_chg && !key_irq));

    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> key_chg);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |=> !key_irq);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (key_chg && !key_chg_clr) |=> key_chg);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_chg_clr |=> (!key_chg || key_irq));
endmodule

bind vfd_scan_ctrl vfd_scan_sva #(.DIG_N(DIG_N), .SEG_N(SEG_N), .EXT_N(EXT_N)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_seg_mode (cfg_seg_mode),
    .dig_out      (dig_out),
    .seg_out      (seg_out),
    .key_chg      (key_chg),
    .key_chg_clr  (key_chg_clr),
    .key_irq      (key_irq)
);

// File: tb/tb_vfd_scan_ctrl.sv
module tb_vfd_scan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cfg_digits = 4'd3;
    logic [7:0]   cfg_slot_len = 8'd8;
    logic [2:0]   cfg_dim = 3'd7;
    logic         cfg_key_en = 1'b0;
    logic [7:0]   cfg_seg_mode = 8'h00;
    logic [3:0]   ram_addr;
    logic [31:0]  ram_data;
    logic [15:0]  dig_out;
    logic [23:0]  seg_out;
    logic [7:0]   key_ret;
    logic [127:0] key_state;
    logic         key_chg;
    logic         key_chg_clr = 1'b0;
    logic         key_irq;

    logic [31:0]  mem  [0:15];
    logic [7:0]   keys [0:15];

    int n_run = 0;
    int n_fail = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_scan_ctrl #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_digits(cfg_digits), .cfg_slot_len(cfg_slot_len),
        .cfg_dim(cfg_dim), .cfg_key_en(cfg_key_en), .cfg_seg_mode(cfg_seg_mode),
        .ram_addr(ram_addr), .ram_data(ram_data), .dig_out(dig_out), .seg_out(seg_out),
        .key_ret(key_ret), .key_state(key_state), .key_chg(key_chg),
        .key_chg_clr(key_chg_clr), .key_irq(key_irq)
    );

    assign ram_data = mem[ram_addr];

    always_comb begin
        key_ret = '0;
        for (int c = 0; c < 16; c++) if (seg_out[c]) key_ret |= keys[c];
    end

    always @(negedge clk) if (rst_n && key_irq) irq_cnt++;

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic int lit_ticks(input int dim, input int len);
        int leff, p;
        leff = (len == 0) ? 1 : len;
        p = ((dim + 1) * leff) / 8;
        return (p == 0) ? 1 : p;
    endfunction

    function automatic logic [15:0] exp_dig(input int d, input logic [7:0] mode, input logic [31:0] p);
        logic [15:0] v;
        v = '0;
        v[d] = 1'b1;
        for (int k = 0; k < 8; k++) if (mode[k]) v[8+k] = p[31-k];
        return v;
    endfunction

    function automatic logic [127:0] keys_vec();
        logic [127:0] v;
        for (int c = 0; c < 16; c++) v[c*8 +: 8] = keys[c];
        return v;
    endfunction

    // Cycle-by-cycle check of nfr frames from a fresh digit-0 start (R1..R5, R7).
    task automatic run_frames(input int n, input int dim, input int len, input bit ken,
                              input logic [7:0] mode, input int nfr, input string tag);
        int leff, lit, bad, guard, col, prev_col;
        bit prev_zero;
        leff = (len == 0) ? 1 : len;
        lit = lit_ticks(dim, len);
        prev_zero = 1'b0;
        guard = 0;
        while (guard < 20000) begin
            @(negedge clk);
            guard++;
            if (dig_out[0] && prev_zero) break;
            prev_zero = (dig_out == '0 && seg_out == '0);
        end
        prev_col = -1;
        for (int fr = 0; fr < nfr; fr++) begin
            for (int d = 0; d <= n; d++) begin
                bad = 0;
                for (int c = 0; c < lit*DIV; c++) begin
                    if (dig_out !== exp_dig(d, mode, mem[d]) || seg_out !== mem[d][23:0] || ram_addr !== 4'(d)) bad++;
                    @(negedge clk);
                end
                for (int c = 0; c < (leff - lit + 2)*DIV; c++) begin
                    if (dig_out !== '0 || seg_out !== '0) bad++;
                    @(negedge clk);
                end
                chk(bad == 0, $sformatf("%s R1 R2 R3 R4 R5 digit %0d", tag, d),
                    $sformatf("%0d mismatching cycles", bad), "0");
            end
            if (ken) begin
                bad = 0;
                col = -1;
                for (int b = 0; b < 24; b++) if (seg_out[b]) col = b;
                for (int c = 0; c < leff*DIV; c++) begin
                    if (dig_out !== '0 || col < 0 || col > 15 || seg_out !== (24'd1 << col)) bad++;
                    @(negedge clk);
                end
                for (int c = 0; c < 2*DIV; c++) begin
                    if (dig_out !== '0 || seg_out !== '0) bad++;
                    @(negedge clk);
                end
                chk(bad == 0, {tag, " R7 key slot drive"}, $sformatf("%0d bad cycles", bad), "0");
                if (prev_col >= 0)
                    chk(col == (prev_col + 1) % 16, {tag, " R7 column step"},
                        $sformatf("%0d", col), $sformatf("%0d", (prev_col + 1) % 16));
                prev_col = col;
            end
        end
    endtask

    task automatic apply_cfg(input int n, input int dim, input int len, input bit ken, input logic [7:0] mode);
        @(negedge clk);
        cfg_digits = 4'(n);
        cfg_dim = 3'(dim);
        cfg_slot_len = 8'(len);
        cfg_key_en = ken;
        cfg_seg_mode = mode;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        key_chg_clr = 1'b1;
        @(negedge clk);
        key_chg_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int n, dim, len, base_irq, guard;
        logic [7:0] mode;
        logic [127:0] snap;
        bit seen;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 16; i++) begin
            mem[i] = $urandom;
            keys[i] = 8'h00;
        end

        // R6: reset state
        repeat (3) @(negedge clk);
        chk(dig_out == '0 && seg_out == '0, "R6 outputs in reset",
            $sformatf("%h/%h", dig_out, seg_out), "0/0");
        chk(key_state == '0 && !key_chg && !key_irq, "R6 key state in reset",
            $sformatf("%h %b %b", key_state, key_chg, key_irq), "0 0 0");
        rst_n = 1'b1;
        @(negedge clk);
        chk(dig_out == '0 && seg_out == '0 && !key_chg, "R6 outputs after reset",
            $sformatf("%h/%h/%b", dig_out, seg_out, key_chg), "0/0/0");

        // Directed display cases
        apply_cfg(3, 7, 8, 1'b0, 8'h00); run_frames(3, 7, 8, 1'b0, 8'h00, 2, "full");
        apply_cfg(3, 0, 8, 1'b0, 8'h00); run_frames(3, 0, 8, 1'b0, 8'h00, 1, "R4 min dim");
        apply_cfg(2, 3, 5, 1'b0, 8'h00); run_frames(2, 3, 5, 1'b0, 8'h00, 1, "R4 partial");
        apply_cfg(1, 7, 0, 1'b0, 8'h00); run_frames(1, 7, 0, 1'b0, 8'h00, 2, "R3 zero len");
        apply_cfg(0, 5, 6, 1'b0, 8'h00); run_frames(0, 5, 6, 1'b0, 8'h00, 3, "R1 single digit");
        apply_cfg(15, 7, 4, 1'b0, 8'hA5); run_frames(15, 7, 4, 1'b0, 8'hA5, 1, "R5 ext segs");

        // Random configurations
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 16; i++) mem[i] = $urandom;
            n = $urandom_range(15, 0);
            dim = $urandom_range(7, 0);
            len = $urandom_range(12, 1);
            mode = 8'($urandom);
            apply_cfg(n, dim, len, 1'b0, mode);
            run_frames(n, dim, len, 1'b0, mode, 1, "random");
        end

        // Key scanning: R7 R8 R9
        for (int i = 0; i < 16; i++) keys[i] = 8'($urandom);
        keys[5] = 8'h3C;
        apply_cfg(2, 7, 4, 1'b1, 8'h00);
        run_frames(2, 7, 4, 1'b1, 8'h00, 34, "keys");
        chk(key_state == keys_vec(), "R8 captured matrix", $sformatf("%h", key_state),
            $sformatf("%h", keys_vec()));
        chk(key_chg == 1'b1, "R9 change flag after first scan", $sformatf("%b", key_chg), "1");
        chk(irq_cnt >= 1, "R9 interrupt seen", $sformatf("%0d", irq_cnt), ">=1");

        // R10 sticky, R9 no change -> no flag
        run_frames(2, 7, 4, 1'b1, 8'h00, 2, "sticky");
        chk(key_chg == 1'b1, "R10 flag sticky", $sformatf("%b", key_chg), "1");
        pulse_clr();
        @(negedge clk);
        chk(key_chg == 1'b0, "R10 flag cleared", $sformatf("%b", key_chg), "0");
        base_irq = irq_cnt;
        run_frames(2, 7, 4, 1'b1, 8'h00, 34, "stable");
        chk(key_chg == 1'b0 && irq_cnt == base_irq, "R9 stable matrix raises nothing",
            $sformatf("%b/%0d", key_chg, irq_cnt - base_irq), "0/0");

        // R9 single detection for one changed key
        keys[9] = keys[9] ^ 8'h01;
        run_frames(2, 7, 4, 1'b1, 8'h00, 34, "change");
        chk(key_chg == 1'b1 && irq_cnt == base_irq + 1, "R9 one change one interrupt",
            $sformatf("%b/%0d", key_chg, irq_cnt - base_irq), "1/1");
        chk(key_state == keys_vec(), "R8 updated matrix", $sformatf("%h", key_state),
            $sformatf("%h", keys_vec()));

        // R10 collision: clear held high while a change is detected
        pulse_clr();
        keys[2] = keys[2] ^ 8'hFF;
        @(negedge clk);
        key_chg_clr = 1'b1;
        seen = 1'b0;
        guard = 0;
        while (!seen && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (key_irq) seen = 1'b1;
        end
        chk(seen && key_chg == 1'b1, "R10 set wins over clear",
            $sformatf("%b/%b", seen, key_chg), "1/1");
        @(negedge clk);
        chk(key_chg == 1'b0, "R10 held clear takes effect next edge", $sformatf("%b", key_chg), "0");
        key_chg_clr = 1'b0;

        // R11: scanning disabled
        apply_cfg(2, 7, 4, 1'b0, 8'h00);
        run_frames(2, 7, 4, 1'b0, 8'h00, 1, "R11 flush");
        pulse_clr();
        snap = key_state;
        for (int i = 0; i < 16; i++) keys[i] = ~keys[i];
        run_frames(2, 7, 4, 1'b0, 8'h00, 3, "R11 disabled");
        chk(key_state == snap && !key_chg, "R11 key state untouched",
            $sformatf("%h/%b", key_state, key_chg), $sformatf("%h/0", snap));

        finish_up();
    end
endmodule